// File: doc/BRIEF.md
# Key-Protected Watchdog Counter

This block is a watchdog counter with a guarded register set. Software cannot change its configuration with a single write. It must first write one key value to a key register and then a second key value to another key register. Only then does exactly one following write to a guarded register take effect. The guarded registers are the event status, the match value and the arm control. After that one write the block locks again, so each guarded write needs its own key pair.

The counter advances by one on each clock cycle in which the tick input is high and counting is armed. When the count equals the match value on an armed tick, the event flag is set and the counter holds. If the reset action is also armed, a reset request output pulses high for one cycle. Software clears the event through a guarded write to the status register. The current count can be read at any time.

Registers sit at word addresses on a simple write-strobe bus with a combinational read port. Address 0 is status, 1 is match value, 2 is arm control, 3 is the read-only count, 4 is the first key and 5 is the second key.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, status reads 0, match value reads all ones, arm control reads 0, count reads 0 and `wd_reset` is low.
- R2: A write of 0xBABA to address 4 followed by a write of 0xEB10 to address 5 unlocks the block, and the next write to address 0, 1 or 2 takes effect.
- R3: Any single write made while unlocked relocks the block, so a second guarded write without a fresh key pair is ignored.
- R4: A wrong key value, a second key without a preceding first key, or any other write between the two keys leaves the block locked. A guarded write made while locked is ignored. A correct first key always restarts the sequence.
- R5: While arm bit 0 is set and status is clear, the count rises by one on every cycle with `tick_en` high and holds otherwise.
- R6: On a tick where arm bit 0 is set and the count equals the match value, status bit 0 (also `wd_event`) sets from the next cycle on and the count holds while status is set.
- R7: The match that sets status drives `wd_reset` high for exactly one cycle when arm bit 1 is set. With arm bit 1 clear, it stays low.
- R8: A guarded write to status with data bit 0 equal to 0 clears status and the count. With bit 0 equal to 1, the write leaves status unchanged.
- R9: A guarded write to arm control (data bits 1:0) clears the count to 0 and leaves status unchanged.
- R10: Address 3 returns the count and ignores writes. A write to it still consumes an unlock. The key addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable for this cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for `bus_addr` |
| wd_event | output | 1 | Status event flag |
| wd_reset | output | 1 | One-cycle reset request |

## Verification
The unlock logic is driven with a table of write sequences: a correct key pair, swapped keys, a corrupted first or second key, a repeated first key, a stray write between the keys, and an unlock spent on the count register. After each step the match value is read back, which shows whether that exact sequence granted a write. The counter is then run with the tick idle and active, to a match with the reset action off and then on. This separates a plain status event from a reset request and shows that the counter holds after a match. Status writes with bit 0 set and clear show which value clears the event.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int          CW         = 32,
  parameter int          AW         = 3,
  parameter logic [31:0] KEY_FIRST  = 32'h0000_BABA,
  parameter logic [31:0] KEY_SECOND = 32'h0000_EB10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          wd_event,
  output logic          wd_reset
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_MTCH = AW'(1);
  localparam logic [AW-1:0] A_ARM  = AW'(2);
  localparam logic [AW-1:0] A_CNT  = AW'(3);
  localparam logic [AW-1:0] A_KEY1 = AW'(4);
  localparam logic [AW-1:0] A_KEY2 = AW'(5);
  localparam logic [CW-1:0] K1 = CW'(KEY_FIRST);
  localparam logic [CW-1:0] K2 = CW'(KEY_SECOND);

  typedef enum logic [1:0] {S_LOCK, S_HALF, S_OPEN} lock_t;

  lock_t         lock_q, lock_d;
  logic [CW-1:0] cnt_q, match_q;
  logic [1:0]    arm_q;
  logic          stat_q;
  logic          unlocked, grant, wr_stat, wr_mtch, wr_arm, clr_ev, fire;

  assign unlocked = (lock_q == S_OPEN);
  assign grant    = bus_wr && unlocked;
  assign wr_stat  = grant && (bus_addr == A_STAT);
  assign wr_mtch  = grant && (bus_addr == A_MTCH);
  assign wr_arm   = grant && (bus_addr == A_ARM);
  assign clr_ev   = wr_stat && !bus_wdata[0];
  assign fire     = arm_q[0] && tick_en && !stat_q && (cnt_q == match_q);

  always_comb begin
    lock_d = lock_q;
    if (bus_wr) begin
      if (bus_addr == A_KEY1 && bus_wdata == K1)
        lock_d = S_HALF;
      else if (bus_addr == A_KEY2 && bus_wdata == K2 && lock_q == S_HALF)
        lock_d = S_OPEN;
      else
        lock_d = S_LOCK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= S_LOCK;
      cnt_q    <= '0;
      match_q  <= '1;
      arm_q    <= '0;
      stat_q   <= 1'b0;
      wd_reset <= 1'b0;
    end else begin
      lock_q   <= lock_d;
      wd_reset <= fire && arm_q[1];
      if (wr_mtch) match_q <= bus_wdata;
      if (wr_arm)  arm_q   <= bus_wdata[1:0];
      if (clr_ev)    stat_q <= 1'b0;
      else if (fire) stat_q <= 1'b1;
      if (wr_arm || clr_ev)
        cnt_q <= '0;
      else if (arm_q[0] && tick_en && !stat_q && !fire)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = CW'(stat_q);
      A_MTCH:  bus_rdata = match_q;
      A_ARM:   bus_rdata = CW'(arm_q);
      A_CNT:   bus_rdata = cnt_q;
      default: bus_rdata = '0;
    endcase
  end

  assign wd_event = stat_q;
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int CW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [CW-1:0] bus_wdata,
  input logic          unlocked,
  input logic [CW-1:0] match_q,
  input logic [CW-1:0] cnt_q,
  input logic [1:0]    arm_q,
  input logic          wd_event,
  input logic          wd_reset
);
  // R7
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |=> !wd_reset);
  // R7
  rst_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> $past(arm_q[1]));
  // R6
  rst_with_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> wd_event);
  // R4
  locked_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !unlocked && bus_addr == AW'(1)) |=> $stable(match_q));
  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unlocked) |=> !unlocked);
  // R8
  event_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_event) |-> $past(unlocked && bus_wr && bus_addr == AW'(0) && !bus_wdata[0]));
  // R9
  arm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unlocked && bus_addr == AW'(2)) |=> (cnt_q == '0));
  // R6
  hold_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_event && !bus_wr) |=> $stable(cnt_q));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .unlocked(unlocked), .match_q(match_q),
  .cnt_q(cnt_q), .arm_q(arm_q), .wd_event(wd_event), .wd_reset(wd_reset)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int CW = 32;
  localparam int AW = 3;
  localparam int NV = 25;

  logic          clk = 0, rst_n = 0, tick_en = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          wd_event, wd_reset;
  int            checks = 0, errors = 0, pulses = 0, cyc = 0;
  bit            done = 0;

  keyed_watchdog #(.CW(CW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_event(wd_event), .wd_reset(wd_reset)
  );

  always #10 clk = ~clk;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && wd_reset) pulses <= pulses + 1;
  end

  // {addr, wdata, expected match readback}
  localparam logic [66:0] VEC [NV] = '{
    {3'd1, 32'h10,   32'hFFFF_FFFF},
    {3'd4, 32'hBABA, 32'hFFFF_FFFF},
    {3'd5, 32'hEB10, 32'hFFFF_FFFF},
    {3'd1, 32'h20,   32'h20},
    {3'd1, 32'h30,   32'h20},
    {3'd5, 32'hEB10, 32'h20},
    {3'd1, 32'h40,   32'h20},
    {3'd4, 32'hBABB, 32'h20},
    {3'd5, 32'hEB10, 32'h20},
    {3'd1, 32'h50,   32'h20},
    {3'd4, 32'hBABA, 32'h20},
    {3'd5, 32'hEB11, 32'h20},
    {3'd1, 32'h60,   32'h20},
    {3'd4, 32'hBABA, 32'h20},
    {3'd4, 32'hBABA, 32'h20},
    {3'd5, 32'hEB10, 32'h20},
    {3'd1, 32'h70,   32'h70},
    {3'd4, 32'hBABA, 32'h70},
    {3'd3, 32'h0,    32'h70},
    {3'd5, 32'hEB10, 32'h70},
    {3'd1, 32'h80,   32'h70},
    {3'd4, 32'hBABA, 32'h70},
    {3'd5, 32'hEB10, 32'h70},
    {3'd3, 32'h5,    32'h70},
    {3'd1, 32'h90,   32'h70}
  };

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic prot(input logic [AW-1:0] a, input logic [CW-1:0] d);
    wr(3'd4, 32'hBABA);
    wr(3'd5, 32'hEB10);
    wr(a, d);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  initial begin
    logic [CW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); chk("R1 status", v, 0);
    rd(3'd1, v); chk("R1 match", v, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R1 arm", v, 0);
    rd(3'd3, v); chk("R1 count", v, 0);
    chk("R1 wd_reset", CW'(wd_reset), 0);

    // R2 R3 R4 unlock sequence table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(3'd1, v);
      chk($sformatf("R2 R3 R4 row %0d", i), v, VEC[i][31:0]);
    end

    // R5 counting with tick idle and active
    prot(3'd1, 32'd5);
    prot(3'd2, 32'd1);
    rd(3'd3, v); chk("R9 arm clears count", v, 0);
    repeat (3) @(negedge clk);
    rd(3'd3, v); chk("R5 hold without tick", v, 0);
    ticks(3);
    rd(3'd3, v); chk("R5 count after 3 ticks", v, 3);
    ticks(2);
    rd(3'd0, v); chk("R6 no event before match tick", v, 0);
    ticks(1);
    rd(3'd0, v); chk("R6 event on match", v, 1);
    ticks(2);
    rd(3'd3, v); chk("R6 count holds", v, 5);
    chk("R7 no reset pulse when bit1 clear", pulses, 0);

    // R8 status clearing
    prot(3'd0, 32'd1);
    rd(3'd0, v); chk("R8 write 1 keeps event", v, 1);
    prot(3'd0, 32'd0);
    rd(3'd0, v); chk("R8 write 0 clears event", v, 0);
    rd(3'd3, v); chk("R8 clear zeroes count", v, 0);

    // R7 reset action armed
    prot(3'd2, 32'd3);
    ticks(9);
    chk("R7 single reset pulse", pulses, 1);
    rd(3'd0, v); chk("R7 event set", v, 1);
    rd(3'd3, v); chk("R6 count held at match", v, 5);

    // R9 arm write keeps status
    prot(3'd2, 32'd3);
    rd(3'd3, v); chk("R9 count cleared", v, 0);
    rd(3'd0, v); chk("R9 status kept", v, 1);

    // R10 count read-only, keys read 0
    prot(3'd3, 32'd7);
    rd(3'd3, v); chk("R10 count write ignored", v, 0);
    wr(3'd1, 32'd9);
    rd(3'd1, v); chk("R10 unlock consumed", v, 5);
    wr(3'd4, 32'hBABA);
    rd(3'd4, v); chk("R10 key1 reads 0", v, 0);
    rd(3'd5, v); chk("R10 key2 reads 0", v, 0);
    wr(3'd0, 32'd0);
    rd(3'd0, v); chk("R4 half-open status write ignored", v, 1);

    done = 1;
  end

  initial begin
    wait (done || cyc > 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=%0d expected=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule